// File: doc/BRIEF.md
# Register Write-Readback Self-Test Sequencer

This block generates test traffic for a serial register-access master that reaches a bank of 32 byte-wide registers in a remote device. For each register it produces a pseudo-random test byte and asks the master to write it. It then asks the master to read the same register back and compares the returned byte with the one it wrote. After each write-read pair it waits for a fixed pause and moves on to the next register. After the last register it starts again at register 0.

Two 32-bit counters are kept. One counts readbacks and the other counts mismatching readbacks. A one-cycle report strobe marks every hundredth readback, so a host can sample the counters at regular intervals. Each request is held on a valid/ready handshake until the master accepts it. Each step then waits for the master's completion pulse. An enable input starts and stops the sweep. A pair that has already started always runs to the end.

Top module: `regtest_sequencer`

## Requirements
- R1: After reset the first register tested is address 0. Each later pair uses the next address, and address 31 is followed by address 0.
- R2: For every address a write request (req_write=1) is issued first. Only after the write's completion pulse is a read request (req_write=0) of the same address issued.
- R3: The test byte equals the low 8 bits of a 16-bit LFSR state, taken modulo 100, so it always lies in 0..99. The LFSR starts at 0xACE1 and steps once per address. A step is a right shift, XORed with 0xB400 when the bit shifted out is 1.
- R4: While req_valid is high and req_ready is low, req_valid, req_write, req_addr and req_wdata stay unchanged.
- R5: After a request is accepted, req_valid stays low until the master's completion pulse (rsp_done) has been sampled.
- R6: err_count rises by exactly 1, one cycle after a read's rsp_done, when rsp_rdata differs from the byte written. Otherwise it is unchanged.
- R7: read_count rises by exactly 1, one cycle after each read's rsp_done, and at no other time.
- R8: report_stb is high for one cycle, in the cycle read_count first shows a nonzero multiple of 100. It is low at all other times.
- R9: After the cycle in which a read's rsp_done is sampled, req_valid stays low for exactly PAUSE_CYCLES cycles (default 4) before the next write request, provided run_en stays high.
- R10: While run_en is low no new pair starts, but a pair already started completes. Raising run_en resumes with the next address.
- R11: Reset clears both counters and report_stb, drops req_valid, sets the address to 0 and reloads the LFSR seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Sweep enable |
| req_valid | output | 1 | Request to the register-access master is pending |
| req_ready | input | 1 | Master accepts the pending request |
| req_write | output | 1 | 1 = write request, 0 = read request |
| req_addr | output | 5 | Register address of the request |
| req_wdata | output | 8 | Test byte to write |
| rsp_done | input | 1 | One-cycle completion pulse from the master |
| rsp_rdata | input | 8 | Byte returned by a read, valid with rsp_done |
| err_count | output | 32 | Number of mismatching readbacks |
| read_count | output | 32 | Number of readbacks |
| report_stb | output | 1 | Pulse on every hundredth readback |

## Verification
The counters and the report strobe change on the clock edge that samples the read's rsp_done. The bench drives rsp_done at a falling edge and reads read_count, err_count and report_stb at the very next falling edge. A request reaches the ports one edge after its state is entered. The bench therefore checks that req_valid has dropped at the falling edge after it raises req_ready, and that the read request is present at the falling edge after the write's completion pulse. The pause is measured by counting falling edges with req_valid low from the one right after the read completion, and the count must equal PAUSE_CYCLES.

// File: rtl/rts_pkg.sv
package rts_pkg;

  localparam int LFSR_W = 16;
  typedef logic [LFSR_W-1:0] lfsr_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_REQ,
    ST_WR_WAIT,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_PAUSE
  } seq_state_t;

  // One step of a right-shifting Galois LFSR.
  function automatic lfsr_t lfsr_next(input lfsr_t s, input lfsr_t mask);
    lfsr_t sh;
    sh = s >> 1;
    return s[0] ? (sh ^ mask) : sh;
  endfunction

  // One conditional subtraction stage of a modulo reduction.
  function automatic lfsr_t fold_once(input lfsr_t v, input lfsr_t span);
    return (v >= span) ? (v - span) : v;
  endfunction

endpackage

// File: rtl/rts_value_gen.sv
module rts_value_gen
  import rts_pkg::*;
#(
  parameter int    DATA_W = 8,
  parameter int    SPAN   = 100,
  parameter lfsr_t SEED   = 16'hACE1,
  parameter lfsr_t MASK   = 16'hB400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  output logic [DATA_W-1:0] value
);

  // Number of subtract stages that bring any DATA_W-bit value below SPAN.
  localparam int NPASS = (((1 << DATA_W) + SPAN - 1) / SPAN) - 1;

  lfsr_t lfsr_q;
  lfsr_t stage [NPASS+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lfsr_q <= SEED;
    else if (advance) lfsr_q <= lfsr_next(lfsr_q, MASK);
  end

  assign stage[0] = LFSR_W'(lfsr_q[DATA_W-1:0]);

  for (genvar g = 0; g < NPASS; g++) begin : g_fold
    assign stage[g+1] = fold_once(stage[g], LFSR_W'(SPAN));
  end

  assign value = stage[NPASS][DATA_W-1:0];

endmodule

// File: rtl/rts_pause_timer.sv
module rts_pause_timer #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic expire
);

  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          last_tick;

  assign last_tick = run_q && (cnt_q == CW'(CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (last_tick) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign active = run_q;
  assign expire = last_tick;

endmodule

// File: rtl/rts_tally.sv
module rts_tally #(
  parameter int CNT_W        = 32,
  parameter int REPORT_EVERY = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             read_evt,
  input  logic             mismatch,
  output logic [CNT_W-1:0] read_count,
  output logic [CNT_W-1:0] err_count,
  output logic             report_stb
);

  localparam int PW = (REPORT_EVERY > 1) ? $clog2(REPORT_EVERY) : 1;

  logic [PW-1:0] phase_q;
  logic          phase_wrap;

  assign phase_wrap = (phase_q == PW'(REPORT_EVERY - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      read_count <= '0;
      err_count  <= '0;
      phase_q    <= '0;
      report_stb <= 1'b0;
    end else begin
      report_stb <= 1'b0;
      if (read_evt) begin
        read_count <= read_count + 1'b1;
        if (mismatch) err_count <= err_count + 1'b1;
        if (phase_wrap) begin
          phase_q    <= '0;
          report_stb <= 1'b1;
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/regtest_sequencer.sv
module regtest_sequencer
  import rts_pkg::*;
#(
  parameter int    NUM_REGS     = 32,
  parameter int    DATA_W       = 8,
  parameter int    VALUE_SPAN   = 100,
  parameter int    CNT_W        = 32,
  parameter int    REPORT_EVERY = 100,
  parameter int    PAUSE_CYCLES = 4,
  parameter lfsr_t LFSR_SEED    = 16'hACE1,
  parameter lfsr_t LFSR_MASK    = 16'hB400,
  localparam int   ADDR_W       = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_done,
  input  logic [DATA_W-1:0] rsp_rdata,
  output logic [CNT_W-1:0]  err_count,
  output logic [CNT_W-1:0]  read_count,
  output logic              report_stb
);

  seq_state_t state_q, state_d;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] test_val;

  // Named internal events.
  logic wr_accept;
  logic rd_accept;
  logic wr_done_evt;
  logic pair_done;
  logic mismatch;
  logic pause_active;
  logic pause_expire;
  logic sweep_wrap;

  assign wr_accept   = (state_q == ST_WR_REQ)  && req_ready;
  assign rd_accept   = (state_q == ST_RD_REQ)  && req_ready;
  assign wr_done_evt = (state_q == ST_WR_WAIT) && rsp_done;
  assign pair_done   = (state_q == ST_RD_WAIT) && rsp_done;
  assign mismatch    = pair_done && (rsp_rdata != test_val);
  assign sweep_wrap  = pair_done && (addr_q == ADDR_W'(NUM_REGS - 1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (run_en)       state_d = ST_WR_REQ;
      ST_WR_REQ:  if (wr_accept)    state_d = ST_WR_WAIT;
      ST_WR_WAIT: if (wr_done_evt)  state_d = ST_RD_REQ;
      ST_RD_REQ:  if (rd_accept)    state_d = ST_RD_WAIT;
      ST_RD_WAIT: if (pair_done)    state_d = ST_PAUSE;
      ST_PAUSE:   if (pause_expire) state_d = run_en ? ST_WR_REQ : ST_IDLE;
      default:                      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          addr_q <= '0;
    else if (sweep_wrap) addr_q <= '0;
    else if (pair_done)  addr_q <= addr_q + 1'b1;
  end

  rts_value_gen #(
    .DATA_W (DATA_W),
    .SPAN   (VALUE_SPAN),
    .SEED   (LFSR_SEED),
    .MASK   (LFSR_MASK)
  ) u_value (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (pair_done),
    .value   (test_val)
  );

  rts_pause_timer #(
    .CYCLES (PAUSE_CYCLES)
  ) u_pause (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (pair_done),
    .active (pause_active),
    .expire (pause_expire)
  );

  rts_tally #(
    .CNT_W        (CNT_W),
    .REPORT_EVERY (REPORT_EVERY)
  ) u_tally (
    .clk        (clk),
    .rst_n      (rst_n),
    .read_evt   (pair_done),
    .mismatch   (mismatch),
    .read_count (read_count),
    .err_count  (err_count),
    .report_stb (report_stb)
  );

  assign req_valid = (state_q == ST_WR_REQ) || (state_q == ST_RD_REQ);
  assign req_write = (state_q == ST_WR_REQ);
  assign req_addr  = addr_q;
  assign req_wdata = test_val;

endmodule

// File: rtl/regtest_sequencer_chk.sv
module regtest_sequencer_chk #(
  parameter int ADDR_W       = 5,
  parameter int DATA_W       = 8,
  parameter int CNT_W        = 32,
  parameter int VALUE_SPAN   = 100,
  parameter int PAUSE_CYCLES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_done,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [CNT_W-1:0]  err_count,
  input logic [CNT_W-1:0]  read_count,
  input logic              report_stb,
  input logic              pause_active,
  input logic              pair_done
);

  logic              armed;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [DATA_W-1:0] wr_val_q;
  int unsigned       pause_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      wr_addr_q <= '0;
      wr_val_q  <= '0;
      pause_len <= 0;
    end else begin
      armed <= 1'b1;
      if (req_valid && req_ready && req_write) begin
        wr_addr_q <= req_addr;
        wr_val_q  <= req_wdata;
      end
      pause_len <= pause_active ? pause_len + 1 : 0;
    end
  end

  // R4
  a_r4_hold_req: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_write) &&
                                   $stable(req_addr) && $stable(req_wdata)));

  // R3
  a_r3_value_range: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |-> (req_wdata < DATA_W'(VALUE_SPAN)));

  // R2
  a_r2_read_same_addr: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (req_valid && !req_write) |-> (req_addr == wr_addr_q));

  // R5
  a_r5_wait_done: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (req_valid && req_ready) |=> !req_valid);

  // R7
  a_r7_read_step: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (read_count != $past(read_count)) |-> (read_count == $past(read_count) + 1'b1));

  // R6
  a_r6_err_step: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (err_count != $past(err_count)) |->
      ((err_count == $past(err_count) + 1'b1) && (read_count == $past(read_count) + 1'b1)));

  // R6
  a_r6_err_on_mismatch: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (pair_done && (rsp_rdata != wr_val_q)) |=> (err_count == $past(err_count) + 1'b1));

  // R8
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    report_stb |=> !report_stb);

  // R8
  a_r8_with_read: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    report_stb |-> (read_count != $past(read_count)));

  // R9
  a_r9_pause_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    pause_active |-> !req_valid);

  // R9
  a_r9_pause_len: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $fell(pause_active) |-> (pause_len == PAUSE_CYCLES));

  // R5
  a_r5_done_only_when_idle_req: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !req_valid);

endmodule

bind regtest_sequencer regtest_sequencer_chk #(
  .ADDR_W       (ADDR_W),
  .DATA_W       (DATA_W),
  .CNT_W        (CNT_W),
  .VALUE_SPAN   (VALUE_SPAN),
  .PAUSE_CYCLES (PAUSE_CYCLES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_write    (req_write),
  .req_addr     (req_addr),
  .req_wdata    (req_wdata),
  .rsp_done     (rsp_done),
  .rsp_rdata    (rsp_rdata),
  .err_count    (err_count),
  .read_count   (read_count),
  .report_stb   (report_stb),
  .pause_active (pause_active),
  .pair_done    (pair_done)
);

// File: tb/sim_regtest_sequencer.sv
`timescale 1ns/1ps
module sim_regtest_sequencer;

  localparam int PAUSE = 4;
  localparam int TARGET_READS = 210;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic        req_write;
  logic [4:0]  req_addr;
  logic [7:0]  req_wdata;
  logic        rsp_done = 1'b0;
  logic [7:0]  rsp_rdata = 8'h00;
  logic [31:0] err_count;
  logic [31:0] read_count;
  logic        report_stb;

  always #10 clk = ~clk;

  regtest_sequencer #(.PAUSE_CYCLES(PAUSE)) u0 (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .err_count(err_count), .read_count(read_count), .report_stb(report_stb)
  );

  typedef struct { int addr; int val; } item_t;
  item_t exp_q[$];

  int n_checks = 0;
  int n_fail   = 0;
  int nread    = 0;
  int nerr     = 0;
  bit finished = 0;
  logic [7:0] mem [32];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Driver side: expected write sequence from the requirements (R1, R3).
  task automatic fill_expect(input int n);
    logic [15:0] s;
    s = 16'hACE1;
    for (int k = 0; k < n; k++) begin
      item_t it;
      it.addr = k % 32;
      it.val  = int'(s[7:0]) % 100;
      exp_q.push_back(it);
      if (s[0]) s = (s >> 1) ^ 16'hB400;
      else      s = s >> 1;
    end
  endtask

  // Monitor / responder: plays the master, pops expectations and compares.
  initial begin : responder
    int pair;
    pair = 0;
    wait (rst_n);
    forever begin
      @(negedge clk);
      if (req_valid) begin
        item_t it;
        int lat;
        bit was_en;
        bit corrupt;
        int gap;
        it = exp_q.pop_front();
        chk(req_write == 1'b1, "R2", req_write, 1);
        chk(int'(req_addr) == it.addr, "R1", req_addr, it.addr);
        chk(int'(req_wdata) == it.val, "R3", req_wdata, it.val);
        lat = pair % 4;
        for (int i = 0; i < lat; i++) begin
          @(negedge clk);
          chk(req_valid && req_write && int'(req_addr) == it.addr && int'(req_wdata) == it.val,
              "R4", req_valid, 1);
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        chk(!req_valid, "R5", req_valid, 0);
        for (int i = 0; i < (pair + 1) % 3; i++) begin
          @(negedge clk);
          chk(!req_valid, "R5", req_valid, 0);
        end
        mem[it.addr] = req_wdata;
        rsp_done = 1'b1;
        @(negedge clk);
        rsp_done = 1'b0;
        chk(req_valid && !req_write, "R2", {req_valid, req_write}, 2);
        chk(int'(req_addr) == it.addr, "R2", req_addr, it.addr);
        chk(!report_stb, "R8", report_stb, 0);
        for (int i = 0; i < lat; i++) begin
          @(negedge clk);
          chk(req_valid && !req_write && int'(req_addr) == it.addr, "R4", req_valid, 1);
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        chk(!req_valid, "R5", req_valid, 0);
        for (int i = 0; i < lat; i++) @(negedge clk);
        nread++;
        corrupt = (nread == 7) || (nread == 100) || (nread == 101);
        if (corrupt) nerr++;
        rsp_rdata = corrupt ? (mem[it.addr] ^ 8'h5A) : mem[it.addr];
        rsp_done = 1'b1;
        @(negedge clk);
        rsp_done = 1'b0;
        chk(int'(read_count) == nread, "R7", read_count, nread);
        chk(int'(err_count) == nerr, "R6", err_count, nerr);
        chk(report_stb == ((nread % 100) == 0), "R8", report_stb, (nread % 100) == 0);
        was_en = run_en;
        gap = 0;
        while (!req_valid && gap < PAUSE + 20) begin
          @(negedge clk);
          gap++;
        end
        if (was_en && run_en) chk(gap == PAUSE, "R9", gap, PAUSE);
        pair++;
      end
    end
  end

  initial begin : main
    fill_expect(TARGET_READS + 20);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk(read_count == 0, "R11", read_count, 0);
    chk(err_count == 0, "R11", err_count, 0);
    chk(!req_valid, "R11", req_valid, 0);
    chk(!report_stb, "R11", report_stb, 0);
    // R10: nothing starts while disabled
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(!req_valid, "R10", req_valid, 0);
    end
    run_en = 1'b1;
    wait (nread >= 50);
    @(negedge clk);
    while (!(req_valid && req_write)) @(negedge clk);
    run_en = 1'b0;   // R10: drop enable during the write of pair 51
    wait (nread >= 51);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk(!req_valid, "R10", req_valid, 0);
    end
    chk(read_count == 51, "R10", read_count, 51);
    run_en = 1'b1;
    wait (nread >= TARGET_READS);
    repeat (10) @(negedge clk);
    chk(err_count == 3, "R6", err_count, 3);
    chk(read_count == TARGET_READS, "R7", read_count, TARGET_READS);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d reads expected %0d", nread, TARGET_READS);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule